// File: doc/BRIEF.md
# Base-Bounds Address Translator

This block turns a virtual address into a physical address without a page table or lookup cache. The top bits of the virtual address pick one of four fixed segments. The lower half of the space is the user segment. An address there is compared with a bound register and then moved by adding a base register. Instruction fetches use one base/bound pair, and loads and stores use a second pair. The upper half of the space holds three kernel segments. These segments have a fixed mapping and never look at the base/bound registers. Two of them fold onto low physical memory, one cached and one uncached. The top quarter passes through unchanged and is cached.

Each request enters on a valid/ready channel and carries an address, an access type and a privilege flag. The answer leaves on a second valid/ready channel one cycle after the request is accepted. The answer holds the physical address, a cached flag, an address-error flag and the faulting virtual address. A request is accepted when the response register is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response holds still and `req_ready` stays low. Software loads the four relocation registers through a plain write port.

Top module: `bbx_xlate`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1. All four relocation registers reset to zero, so a user-segment data access to address 0 succeeds with physical address 0, and one to address 1 faults.
- R2: A user-segment access (address MSB = 0) with `req_acc` = 0 (fetch) is checked against the instruction bound and relocated by the instruction base.
- R3: A user-segment access with `req_acc` = 1 (load), 2 (store) or 3 (treated as data) is checked against the data bound and relocated by the data base.
- R4: An in-bounds user access (virtual address <= bound, compared unsigned) returns physical address = virtual address + base, modulo 2^ADDR_W, with `rsp_cached` = 1 and `rsp_err` = 0.
- R5: An out-of-bounds user access returns `rsp_err` = 1, `rsp_badva` = the virtual address, `rsp_pa` = 0 and `rsp_cached` = 0. Whenever `rsp_err` = 0, `rsp_badva` is 0.
- R6: A kernel-mode access whose top three address bits are 100 returns the address with those three bits cleared, cached.
- R7: A kernel-mode access whose top three address bits are 101 returns the address with those three bits cleared, uncached.
- R8: A kernel-mode access whose top two address bits are 11 returns the address unchanged, cached.
- R9: A user-mode access (`req_user` = 1) to any address with MSB = 1 raises `rsp_err` and reports the address in `rsp_badva`.
- R10: Kernel-segment results do not depend on the base/bound register contents.
- R11: The response appears in the cycle after acceptance. While `rsp_valid` = 1 and `rsp_ready` = 0, every response output stays stable and `req_ready` stays 0.
- R12: `cfg_we` writes `cfg_wdata` into the register chosen by `cfg_sel`: 0 = instruction base, 1 = instruction bound, 2 = data base, 3 = data bound. The write applies to requests accepted in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_va | input | ADDR_W | Virtual address |
| req_acc | input | 2 | Access type: 0 fetch, 1 load, 2 store, 3 data |
| req_user | input | 1 | 1 = user privilege, 0 = kernel |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_pa | output | ADDR_W | Physical address (0 on error) |
| rsp_cached | output | 1 | Access is cacheable |
| rsp_err | output | 1 | Address-error exception |
| rsp_badva | output | ADDR_W | Faulting virtual address (0 when no error) |
| cfg_we | input | 1 | Relocation register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | ADDR_W | Register write value |

## Verification
The bench builds the translator with ADDR_W = 8, so the four segments span 256 addresses in total. At that width it can sweep every virtual address with every access type and both privilege levels under four different relocation settings. Those settings include a base that makes the sum wrap, a bound of zero and a bound above the user segment. Every bound edge, every segment edge and the adder wraparound are therefore hit exactly. Separate sequences cover reset values, register select decoding and a stalled response overlapped with a waiting request.

// File: rtl/bbx_pkg.sv
package bbx_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_DATA  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    SEG_USER   = 2'd0,
    SEG_KCACHE = 2'd1,
    SEG_KUNCA  = 2'd2,
    SEG_KHIGH  = 2'd3
  } seg_e;

  localparam int NUM_RELOC = 4;
  localparam int SEL_IBASE  = 0;
  localparam int SEL_IBOUND = 1;
  localparam int SEL_DBASE  = 2;
  localparam int SEL_DBOUND = 3;
endpackage

// File: rtl/bbx_regs.sv
module bbx_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [1:0]   sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ibase,
  output logic [W-1:0] ibound,
  output logic [W-1:0] dbase,
  output logic [W-1:0] dbound
);
  import bbx_pkg::*;

  logic [W-1:0] regs [NUM_RELOC];

  for (genvar i = 0; i < NUM_RELOC; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[i] <= '0;
      else if (we && (sel == 2'(i)))
        regs[i] <= wdata;
    end
  end

  assign ibase  = regs[SEL_IBASE];
  assign ibound = regs[SEL_IBOUND];
  assign dbase  = regs[SEL_DBASE];
  assign dbound = regs[SEL_DBOUND];
endmodule

// File: rtl/bbx_seg_decode.sv
module bbx_seg_decode #(
  parameter int W = 32
) (
  input  logic [W-1:0]   va,
  output bbx_pkg::seg_e  seg,
  output logic [W-1:0]   kpa
);
  import bbx_pkg::*;

  localparam int SEG_BITS = 3;
  localparam int LOW_W    = W - SEG_BITS;

  logic [SEG_BITS-1:0] top;
  assign top = va[W-1 -: SEG_BITS];

  always_comb begin
    if (!top[2])         seg = SEG_USER;
    else if (top[1])     seg = SEG_KHIGH;
    else if (top[0])     seg = SEG_KUNCA;
    else                 seg = SEG_KCACHE;
  end

  assign kpa = {{SEG_BITS{1'b0}}, va[LOW_W-1:0]};
endmodule

// File: rtl/bbx_relocate.sv
module bbx_relocate #(
  parameter int W = 32
) (
  input  logic [W-1:0] va,
  input  logic         fetch,
  input  logic [W-1:0] ibase,
  input  logic [W-1:0] ibound,
  input  logic [W-1:0] dbase,
  input  logic [W-1:0] dbound,
  output logic [W-1:0] pa,
  output logic         in_bounds
);
  logic [W-1:0] base, bound;

  assign base      = fetch ? ibase  : dbase;
  assign bound     = fetch ? ibound : dbound;
  assign in_bounds = (va <= bound);
  assign pa        = va + base;
endmodule

// File: rtl/bbx_xlate.sv
module bbx_xlate #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_va,
  input  logic [1:0]        req_acc,
  input  logic              req_user,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_pa,
  output logic              rsp_cached,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] rsp_badva,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata
);
  import bbx_pkg::*;

  logic [ADDR_W-1:0] ibase, ibound, dbase, dbound;
  logic [ADDR_W-1:0] user_pa, kern_pa;
  logic              in_bounds, fetch;
  seg_e              seg;

  logic [ADDR_W-1:0] nx_pa;
  logic              nx_cached, nx_err;

  bbx_regs #(.W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .ibase(ibase), .ibound(ibound), .dbase(dbase), .dbound(dbound)
  );

  bbx_seg_decode #(.W(ADDR_W)) u_seg (
    .va(req_va), .seg(seg), .kpa(kern_pa)
  );

  assign fetch = (acc_e'(req_acc) == ACC_FETCH);

  bbx_relocate #(.W(ADDR_W)) u_rel (
    .va(req_va), .fetch(fetch),
    .ibase(ibase), .ibound(ibound), .dbase(dbase), .dbound(dbound),
    .pa(user_pa), .in_bounds(in_bounds)
  );

  always_comb begin
    nx_err    = 1'b0;
    nx_cached = 1'b1;
    nx_pa     = '0;
    unique case (seg)
      SEG_USER: begin
        nx_err = !in_bounds;
        nx_pa  = user_pa;
      end
      SEG_KCACHE: begin
        nx_err = req_user;
        nx_pa  = kern_pa;
      end
      SEG_KUNCA: begin
        nx_err    = req_user;
        nx_pa     = kern_pa;
        nx_cached = 1'b0;
      end
      default: begin
        nx_err = req_user;
        nx_pa  = req_va;
      end
    endcase
    if (nx_err) begin
      nx_pa     = '0;
      nx_cached = 1'b0;
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_pa     <= '0;
      rsp_cached <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_badva  <= '0;
    end else if (req_valid && req_ready) begin
      rsp_valid  <= 1'b1;
      rsp_pa     <= nx_pa;
      rsp_cached <= nx_cached;
      rsp_err    <= nx_err;
      rsp_badva  <= nx_err ? req_va : '0;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/bbx_xlate_chk.sv
module bbx_xlate_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic [W-1:0] req_va,
  input logic         req_user,
  input logic         rsp_valid,
  input logic         rsp_ready,
  input logic [W-1:0] rsp_pa,
  input logic         rsp_cached,
  input logic         rsp_err,
  input logic [W-1:0] rsp_badva
);
  // R11: a stalled response is held
  assert_hold_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_cached)
      && $stable(rsp_err) && $stable(rsp_badva));

  // R11: no acceptance while the output is stalled
  assert_no_accept_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R11: an accepted request yields a response next cycle
  assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R5: an error clears address and cacheability
  assert_err_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_pa == '0 && !rsp_cached);

  // R5: no error, no faulting address
  assert_badva_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_err |-> rsp_badva == '0);

  // R9: user privilege into the upper half faults
  assert_user_kseg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_user && req_va[W-1]
      |=> rsp_err && rsp_badva == $past(req_va));

  // R7: kernel access to the uncached window
  assert_kunca_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_user && req_va[W-1 -: 3] == 3'b101
      |=> !rsp_err && !rsp_cached);
endmodule

bind bbx_xlate bbx_xlate_chk #(.W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_va(req_va), .req_user(req_user), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_cached(rsp_cached),
  .rsp_err(rsp_err), .rsp_badva(rsp_badva)
);

// File: tb/test_bbx_xlate.sv
module test_bbx_xlate;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [W-1:0] req_va = '0;
  logic [1:0] req_acc = '0;
  logic req_user = 1'b0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [W-1:0] rsp_pa, rsp_badva;
  logic rsp_cached, rsp_err;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [W-1:0] cfg_wdata = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bbx_xlate #(.ADDR_W(W)) i_bbx_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_acc(req_acc), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
    .rsp_cached(rsp_cached), .rsp_err(rsp_err), .rsp_badva(rsp_badva),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = W'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(input int va, input int acc, input bit user);
    @(negedge clk);
    req_valid = 1'b1; req_va = W'(va); req_acc = 2'(acc); req_user = user;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_one(input int va, input int acc, input bit user,
                           input int ib, input int ibd, input int db, input int dbd);
    int epa; bit ec; bit ee; string tag; string etag;
    int top;
    bit fetch;
    top = (va >> 5) & 7;
    fetch = (acc == 0);
    ee = 0; ec = 1; epa = 0;
    if (top < 4) begin
      tag = fetch ? "R2" : "R3";
      if (va <= (fetch ? ibd : dbd)) epa = (va + (fetch ? ib : db)) % 256;
      else ee = 1;
      etag = ee ? "R5" : "R4";
    end else if (user) begin
      ee = 1; tag = "R9"; etag = "R9";
    end else begin
      etag = "R10";
      if (top == 4) begin epa = va & 8'h1f; tag = "R6"; end
      else if (top == 5) begin epa = va & 8'h1f; ec = 0; tag = "R7"; end
      else begin epa = va; tag = "R8"; end
    end
    if (ee) begin epa = 0; ec = 0; end
    issue(va, acc, user);
    chk(rsp_valid == 1'b1, "R11", "rsp_valid", int'(rsp_valid), 1);
    chk(rsp_err == ee, etag, "rsp_err", int'(rsp_err), int'(ee));
    chk(int'(rsp_pa) == epa && rsp_cached == ec, tag, "pa/cached",
        int'({rsp_cached, rsp_pa}), (int'(ec) << 8) | epa);
    chk(int'(rsp_badva) == (ee ? va : 0), ee ? "R5" : tag, "rsp_badva",
        int'(rsp_badva), ee ? va : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
    issue(0, 1, 1'b1);
    chk(rsp_err == 1'b0 && rsp_pa == '0, "R1", "va0 err/pa", int'({rsp_err, rsp_pa}), 0);
    issue(1, 1, 1'b1);
    chk(rsp_err == 1'b1, "R1", "va1 err", int'(rsp_err), 1);

    // full sweeps under four relocation settings
    for (int c = 0; c < 4; c++) begin
      int ib, ibd, db, dbd;
      case (c)
        0: begin ib = 8'h10; ibd = 8'h3f; db = 8'hf0; dbd = 8'h7f; end
        1: begin ib = 8'h55; ibd = 8'h00; db = 8'h01; dbd = 8'h40; end
        2: begin ib = 8'h00; ibd = 8'h7f; db = 8'h80; dbd = 8'h00; end
        default: begin ib = 8'haa; ibd = 8'hff; db = 8'h7f; dbd = 8'h20; end
      endcase
      wr(0, ib); wr(1, ibd); wr(2, db); wr(3, dbd);
      for (int u = 0; u < 2; u++)
        for (int a = 0; a < 4; a++)
          for (int v = 0; v < 256; v++)
            check_one(v, a, u[0], ib, ibd, db, dbd);
    end

    // R12: select decoding and write visibility
    wr(0, 0); wr(1, 0); wr(2, 8'h20); wr(3, 8'h10);
    issue(8'h10, 2, 1'b1);
    chk(rsp_err == 1'b0 && rsp_pa == 8'h30, "R12", "store via data pair",
        int'({rsp_err, rsp_pa}), 8'h30);
    issue(8'h10, 0, 1'b1);
    chk(rsp_err == 1'b1, "R12", "fetch via inst pair", int'(rsp_err), 1);

    // R11: stalled response with a waiting request
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_va = 8'h85; req_acc = 2'd1; req_user = 1'b0;
    @(negedge clk);
    req_va = 8'ha7;
    repeat (3) begin
      @(negedge clk);
      chk(rsp_valid && rsp_pa == 8'h05 && rsp_cached, "R11", "held rsp",
          int'({rsp_cached, rsp_pa}), 9'h105);
      chk(req_ready == 1'b0, "R11", "req_ready stalled", int'(req_ready), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_pa == 8'h07 && !rsp_cached, "R11", "next rsp",
        int'({rsp_cached, rsp_pa}), 8'h07);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11", "drained", int'(rsp_valid), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule